// File: doc/BRIEF.md
# Byte Serial Port Holding-Register Interface

This block sits between a small processor and a byte-wide serializer. The processor sees one registered 8-bit read bus, one select line, a read strobe, a write strobe and an 8-bit write bus. The select line chooses what the next read shows: a status byte or the last byte taken in from the line. A write strobe places a byte into the transmit holding register.

On the line side there are two byte-level valid/ready handshakes. The transmit holding register offers its byte while it is occupied. The receive holding register takes a byte only while it is empty. Each register has an occupancy flag. These flags set the back-pressure on the line side and are reported in the status byte. A write that arrives while the transmit register is still occupied is dropped, and a sticky error bit records it. Baud timing and bit framing belong to the serializer and are not part of this block.

Top module: `sport_iface`

## Requirements
- R1: After reset both holding registers are empty and the overrun bit is clear. `tx_valid` is 0, `rx_ready` is 1, and a status read returns 0x01.
- R2: With `cpu_sel`=0 sampled at a clock edge, `cpu_rdata` shows the status byte after that edge. Bit 0 is 1 when the transmit register is empty. Bit 1 is 1 when the receive register holds an unread byte. Bit 2 is the overrun bit. Bits 7 to 3 are 0.
- R3: With `cpu_sel`=1 sampled at a clock edge, `cpu_rdata` shows the receive holding register after that edge.
- R4: A `cpu_wr` pulse while the transmit register is empty loads `cpu_wdata`. On the next cycle `tx_valid` is 1 and `tx_data` carries the byte.
- R5: While the transmit register is occupied, `tx_valid` stays 1 and `tx_data` stays unchanged until `tx_ready` is seen. That handshake edge empties the register.
- R6: A line byte is taken only at an edge where `rx_valid` and `rx_ready` are both 1, and only while the receive register is empty. While it is full, `rx_ready` is 0 and the stored byte is not replaced.
- R7: A `cpu_rd` pulse with `cpu_sel`=1 clears the receive-full flag on the same edge that places the byte on `cpu_rdata`. A `cpu_rd` pulse with `cpu_sel`=0, or one made while the register is empty, changes no state.
- R8: A `cpu_wr` pulse while the transmit register is occupied is ignored: `tx_data` keeps the older byte. It sets status bit 2, which stays set until reset.
- R9: Every byte value from 0x00 to 0xFF written into one instance arrives unchanged at a second instance across a delayed link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Read select: 0 status byte, 1 receive byte |
| cpu_rd | input | 1 | Read strobe; with select 1 it consumes the receive byte |
| cpu_wr | input | 1 | Write strobe into the transmit holding register |
| cpu_wdata | input | DATA_W | Byte to transmit |
| cpu_rdata | output | DATA_W | Registered read bus |
| tx_valid | output | 1 | Transmit register occupied, byte offered |
| tx_data | output | DATA_W | Offered transmit byte |
| tx_ready | input | 1 | Serializer takes the offered byte |
| rx_valid | input | 1 | Serializer presents a received byte |
| rx_data | input | DATA_W | Received byte |
| rx_ready | output | 1 | Receive register empty, byte can be taken |

## Verification
The bench pushes every byte value from one instance into a second one through a link with a fixed delay. A swapped bit, a lost byte or a status flag that never rises shows up as a wrong or missing byte. It presents a second byte while the receive register is full. A design without back-pressure would overwrite the first byte, and the later read would return the second. It issues status-selected read strobes and reads of an empty register. A design that decoded the strobe without the select would drop the unread byte. Finally, it writes twice while the transmit side is stalled. A design that accepted the second write would change `tx_data`, and one without the sticky bit would read 0x00 instead of 0x04.

// File: rtl/sport_pkg.sv
package sport_pkg;
  // Status byte bit positions; the processor firmware decodes these.
  localparam int STAT_TXE = 0;
  localparam int STAT_RXF = 1;
  localparam int STAT_OVR = 2;
  localparam int STAT_USED = 3;

  typedef struct packed {
    logic ovr;
    logic rx_full;
    logic tx_empty;
  } flags_t;
endpackage

// File: rtl/sport_txhold.sv
module sport_txhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_ready,
  output logic              line_valid,
  output logic [DATA_W-1:0] line_data,
  output logic              overrun
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              ovr_q;
  logic              take;
  logic              load;
  logic              reject;

  // A write is accepted only while the register was empty before the edge.
  assign take   = full_q & line_ready;
  assign load   = wr_en & ~full_q;
  assign reject = wr_en & full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (load) begin
        full_q <= 1'b1;
        data_q <= wr_data;
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (reject) ovr_q <= 1'b1;
    end
  end

  assign line_valid = full_q;
  assign line_data  = data_q;
  assign overrun    = ovr_q;
endmodule

// File: rtl/sport_rxhold.sv
module sport_rxhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  input  logic              consume,
  output logic              line_ready,
  output logic [DATA_W-1:0] hold_data,
  output logic              full
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              drain;

  assign accept = line_valid & ~full_q;
  assign drain  = consume & full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= line_data;
      end else if (drain) begin
        full_q <= 1'b0;
      end
    end
  end

  assign line_ready = ~full_q;
  assign hold_data  = data_q;
  assign full       = full_q;
endmodule

// File: rtl/sport_rdmux.sv
module sport_rdmux
  import sport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  flags_t            flags,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    status           = '0;
    status[STAT_TXE] = flags.tx_empty;
    status[STAT_RXF] = flags.rx_full;
    status[STAT_OVR] = flags.ovr;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= sel ? rx_byte : status;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/sport_iface.sv
module sport_iface
  import sport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready
);
  localparam int STAT_MIN_W = STAT_USED;

  logic              tx_full;
  logic              tx_ovr;
  logic              rx_full;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_consume;
  flags_t            flags;

  initial begin
    if (DATA_W < STAT_MIN_W) $error("DATA_W too small for status byte");
  end

  assign rx_consume = cpu_rd & cpu_sel;

  sport_txhold #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cpu_wr),
    .wr_data    (cpu_wdata),
    .line_ready (tx_ready),
    .line_valid (tx_full),
    .line_data  (tx_data),
    .overrun    (tx_ovr)
  );

  sport_rxhold #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .line_valid (rx_valid),
    .line_data  (rx_data),
    .consume    (rx_consume),
    .line_ready (rx_ready),
    .hold_data  (rx_byte),
    .full       (rx_full)
  );

  assign flags.tx_empty = ~tx_full;
  assign flags.rx_full  = rx_full;
  assign flags.ovr      = tx_ovr;

  sport_rdmux #(.DATA_W(DATA_W)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .sel     (cpu_sel),
    .flags   (flags),
    .rx_byte (rx_byte),
    .rdata   (cpu_rdata)
  );

  assign tx_valid = tx_full;
endmodule

// File: rtl/sport_iface_chk.sv
module sport_iface_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_sel,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!cpu_sel) |-> cpu_rdata[DATA_W-1:3] == '0); // R2

  AST_STATUS_RXF: assert property (@(posedge clk) disable iff (rst)
    !cpu_sel && !rx_ready |=> cpu_rdata[1]); // R2

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && !tx_valid |=> tx_valid && tx_data == $past(cpu_wdata)); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R5

  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> !tx_valid); // R5

  AST_RX_FILL: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready |=> !rx_ready); // R6

  AST_RX_BLOCK: assert property (@(posedge clk) disable iff (rst)
    !rx_ready && !(cpu_rd && cpu_sel) |=> !rx_ready); // R6

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && cpu_sel && !rx_ready |=> rx_ready); // R7
endmodule

bind sport_iface sport_iface_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sport_iface_bench.sv
`timescale 1ns/1ps
module sport_iface_bench;
  localparam int W   = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         a_sel = 0, a_rd = 0, a_wr = 0;
  logic [W-1:0] a_wdata = '0, a_rdata, a_tx_data;
  logic         a_tx_valid, a_tx_ready, a_rx_ready;
  logic         a_rx_valid = 0;
  logic [W-1:0] a_rx_data = '0;

  logic         p_sel = 0, p_rd = 0, p_wr = 0;
  logic [W-1:0] p_wdata = '0, p_rdata, p_tx_data;
  logic         p_tx_valid, p_rx_ready;
  logic         p_tx_ready = 1'b0;
  logic         p_rx_valid;
  logic [W-1:0] p_rx_data;

  sport_iface #(.DATA_W(W)) u_sport_iface (
    .clk(clk), .rst(rst), .cpu_sel(a_sel), .cpu_rd(a_rd), .cpu_wr(a_wr),
    .cpu_wdata(a_wdata), .cpu_rdata(a_rdata), .tx_valid(a_tx_valid),
    .tx_data(a_tx_data), .tx_ready(a_tx_ready), .rx_valid(a_rx_valid),
    .rx_data(a_rx_data), .rx_ready(a_rx_ready));

  sport_iface #(.DATA_W(W)) u_peer (
    .clk(clk), .rst(rst), .cpu_sel(p_sel), .cpu_rd(p_rd), .cpu_wr(p_wr),
    .cpu_wdata(p_wdata), .cpu_rdata(p_rdata), .tx_valid(p_tx_valid),
    .tx_data(p_tx_data), .tx_ready(p_tx_ready), .rx_valid(p_rx_valid),
    .rx_data(p_rx_data), .rx_ready(p_rx_ready));

  // Delayed link from the first instance's transmitter to the peer's receiver.
  int           lk_st;
  int           lk_cnt;
  logic [W-1:0] lk_byte;
  always @(negedge clk) begin
    if (rst) begin
      lk_st <= 0; lk_cnt <= 0; lk_byte <= '0;
      a_tx_ready <= 1'b0; p_rx_valid <= 1'b0; p_rx_data <= '0;
    end else begin
      case (lk_st)
        0: if (a_tx_valid) begin lk_byte <= a_tx_data; a_tx_ready <= 1'b1; lk_st <= 1; end
        1: begin a_tx_ready <= 1'b0; lk_cnt <= LAT; lk_st <= 2; end
        2: if (lk_cnt == 0) lk_st <= 3; else lk_cnt <= lk_cnt - 1;
        3: if (p_rx_ready) begin p_rx_valid <= 1'b1; p_rx_data <= lk_byte; lk_st <= 4; end
        default: begin p_rx_valid <= 1'b0; lk_st <= 0; end
      endcase
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_a(input logic sel, input logic strobe, output logic [W-1:0] v);
    @(negedge clk); a_sel = sel; a_rd = strobe;
    @(negedge clk); a_rd = 0; v = a_rdata;
  endtask

  task automatic rd_p(input logic sel, input logic strobe, output logic [W-1:0] v);
    @(negedge clk); p_sel = sel; p_rd = strobe;
    @(negedge clk); p_rd = 0; v = p_rdata;
  endtask

  task automatic wr_a(input logic [W-1:0] d);
    @(negedge clk); a_wr = 1; a_wdata = d;
    @(negedge clk); a_wr = 0;
  endtask

  task automatic wr_p(input logic [W-1:0] d);
    @(negedge clk); p_wr = 1; p_wdata = d;
    @(negedge clk); p_wr = 0;
  endtask

  task automatic push_a(input logic [W-1:0] d);
    @(negedge clk); a_rx_valid = 1; a_rx_data = d;
    @(negedge clk); a_rx_valid = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    logic [W-1:0] v;
    do_reset();
    // R1 reset state
    chk("R1 tx_valid", {7'b0, a_tx_valid}, 8'h00);
    chk("R1 rx_ready", {7'b0, a_rx_ready}, 8'h01);
    rd_a(1'b0, 1'b0, v); chk("R1 status", v, 8'h01);
    rd_p(1'b0, 1'b0, v); chk("R1 peer status", v, 8'h01);

    // R4 write loads the transmit register
    @(negedge clk); a_wr = 1; a_wdata = 8'hA5;
    @(negedge clk); a_wr = 0;
    chk("R4 tx_valid", {7'b0, a_tx_valid}, 8'h01);
    chk("R4 tx_data", a_tx_data, 8'hA5);
    // R5 handshake empties it (link grabs on this negedge, transfer next edge)
    @(negedge clk);
    chk("R5 drained", {7'b0, a_tx_valid}, 8'h00);
    // wait for arrival at peer, then R2 status and R3/R7 consume
    repeat (LAT + 4) @(negedge clk);
    rd_p(1'b0, 1'b0, v); chk("R2 peer rx full", v, 8'h03);
    rd_p(1'b1, 1'b1, v); chk("R3 peer rx byte", v, 8'hA5);
    rd_p(1'b0, 1'b0, v); chk("R7 cleared", v, 8'h01);

    // R9 exhaustive byte sweep across the link
    for (int b = 0; b < 256; b++) begin
      int tries;
      wr_a(b[W-1:0]);
      tries = 0;
      v = 8'h00;
      while (v[1] !== 1'b1 && tries < 40) begin
        rd_p(1'b0, 1'b0, v);
        tries++;
      end
      chk("R9 arrival flag", {7'b0, v[1]}, 8'h01);
      rd_p(1'b1, 1'b1, v);
      chk("R9 byte", v, b[W-1:0]);
    end

    // R6 back-pressure on the receive side
    push_a(8'h3C);
    chk("R6 ready low when full", {7'b0, a_rx_ready}, 8'h00);
    push_a(8'hE7);
    rd_a(1'b0, 1'b0, v); chk("R2 status rx full", v, 8'h03);
    // R7 status-selected strobe has no effect
    rd_a(1'b0, 1'b1, v); chk("R7 sel0 strobe", v, 8'h03);
    rd_a(1'b0, 1'b0, v); chk("R7 still full", v, 8'h03);
    rd_a(1'b1, 1'b1, v); chk("R6 first byte kept", v, 8'h3C);
    rd_a(1'b0, 1'b0, v); chk("R7 emptied", v, 8'h01);
    rd_a(1'b1, 1'b1, v); chk("R7 empty read stale", v, 8'h3C);
    rd_a(1'b0, 1'b0, v); chk("R7 empty read no effect", v, 8'h01);
    push_a(8'h81);
    rd_a(1'b1, 1'b0, v); chk("R3 new byte", v, 8'h81);
    rd_a(1'b0, 1'b0, v); chk("R7 peek keeps full", v, 8'h03);
    rd_a(1'b1, 1'b1, v);

    // R8 overrun on the stalled peer transmitter
    wr_p(8'h5A);
    rd_p(1'b0, 1'b0, v); chk("R2 tx busy", v, 8'h00);
    wr_p(8'hC3);
    chk("R8 tx_data kept", p_tx_data, 8'h5A);
    chk("R5 held offer", {7'b0, p_tx_valid}, 8'h01);
    rd_p(1'b0, 1'b0, v); chk("R8 overrun bit", v, 8'h04);
    repeat (5) @(negedge clk);
    rd_p(1'b0, 1'b0, v); chk("R8 sticky", v, 8'h04);

    // R1 reset clears overrun and occupancy
    do_reset();
    rd_p(1'b0, 1'b0, v); chk("R1 reset clears", v, 8'h01);
    chk("R1 peer tx_valid", {7'b0, p_tx_valid}, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule